// File: doc/BRIEF.md
# ECC Error Capture and Status Register

This block sits beside a SECDED memory checker and records what the checker reports. Each read can raise a pulse that marks a corrected (single-bit) error or an uncorrectable (multi-bit) error. The pulse arrives together with the read address and the 8-bit syndrome. The block keeps sticky status for the first error it sees, along with the upper address bits and the syndrome of that error. It holds that record until software clears it.

Software reaches the block through one 32-bit control/status word. The word has a plain write strobe and a read value that is always driven. It holds three control bits: scrub disable, system-error enable and NMI enable. The NMI and system-error request outputs are levels. Each one follows its status bit, gated by its enable bit. A scrub request goes out in the same cycle as a corrected read, unless scrubbing is disabled.

Top module: `ecc_err_capture`

## Requirements
- R1: After reset the status word reads 0: no status, address 0, syndrome 0, scrubbing enabled. `nmi_o` and `serr_o` are low and `scrub_en_o` is high.
- R2: A write loads bit 31 (scrub disable), bit 3 (system-error enable) and bit 2 (NMI enable) from the write data. Writes have no effect on bits 30:4.
- R3: When both status bits are 0, a cycle with `sbe_i` high and `mbe_i` low sets bit 0. In the same cycle, bits 30:12 capture `err_addr_i[31:13]` and bits 11:4 capture `syndrome_i`. All of this is visible after that clock edge.
- R4: When both status bits are 0, a cycle with `mbe_i` high sets bit 1 and captures the address and syndrome in the same way.
- R5: If `sbe_i` and `mbe_i` are both high in an armed cycle, the multi-bit error wins. Bit 1 is set and bit 0 stays 0.
- R6: While either status bit is 1, new errors change neither status bit, and the captured address and syndrome stay as they are.
- R7: Writing 1 to bit 0 or bit 1 clears that bit, and writing 0 leaves it unchanged. Capture re-arms only once both bits are 0. The captured address and syndrome stay readable after a clear.
- R8: If an error arrives in an armed cycle that also writes, the capture takes place.
- R9: `nmi_o` is high exactly while bit 0 and bit 2 are both 1. `serr_o` is high exactly while bit 1 and bit 3 are both 1.
- R10: `scrub_en_o` is the inverse of bit 31. In the same cycle, `scrub_req_o` equals `sbe_i & ~mbe_i & ~bit31`, whether or not a capture is armed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sbe_i | input | 1 | Corrected single-bit error on this read |
| mbe_i | input | 1 | Uncorrectable multi-bit error on this read |
| err_addr_i | input | 32 | Address of this read |
| syndrome_i | input | 8 | Syndrome of this read |
| reg_wr_i | input | 1 | Write strobe for the status word |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Status word read value |
| nmi_o | output | 1 | NMI request level |
| serr_o | output | 1 | System-error request level |
| scrub_en_o | output | 1 | Scrub write-back enabled |
| scrub_req_o | output | 1 | Scrub write-back request for the current read |

## Verification
The hardest case to reach is a partial clear. Here one status bit is cleared while the other stays set, so capture must stay disarmed while errors keep arriving. A random write stream rarely leaves the block in exactly that state. The bench therefore drives directed sequences: capture an error, clear only the bit that is not set, inject errors of both kinds, then clear fully. The random phase then mixes dense error pulses with writes that carry random clear masks and control bits. This covers single-bit and double-bit clears, and errors in the same cycle as a clear.

// File: rtl/ecc_cap_pkg.sv
package ecc_cap_pkg;
  localparam int REG_W         = 32;
  localparam int BIT_SBE       = 0;
  localparam int BIT_MBE       = 1;
  localparam int BIT_NMI_EN    = 2;
  localparam int BIT_SERR_EN   = 3;
  localparam int SYN_LSB       = 4;
  localparam int BIT_SCRUB_DIS = 31;

  typedef struct packed {
    logic scrub_dis;
    logic serr_en;
    logic nmi_en;
  } ecc_ctl_t;
endpackage

// File: rtl/ecc_cap_ctrl.sv
module ecc_cap_ctrl
  import ecc_cap_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     wr_i,
  input  ecc_ctl_t wbits_i,
  output ecc_ctl_t ctl_o
);
  ecc_ctl_t ctl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   ctl_q <= '0;
    else if (wr_i) ctl_q <= wbits_i;
  end

  assign ctl_o = ctl_q;
endmodule

// File: rtl/ecc_cap_log.sv
module ecc_cap_log #(
  parameter int ADDR_W = 32,
  parameter int SYND_W = 8,
  parameter int KEEP_W = 19
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sbe_i,
  input  logic              mbe_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [SYND_W-1:0] syn_i,
  input  logic [1:0]        clr_i,
  output logic [1:0]        st_o,
  output logic [KEEP_W-1:0] addr_o,
  output logic [SYND_W-1:0] syn_o
);
  localparam int DROP_W = ADDR_W - KEEP_W;

  logic [1:0]        st_q, st_d;
  logic [KEEP_W-1:0] addr_q;
  logic [SYND_W-1:0] syn_q;
  logic              armed, cap;

  assign armed = (st_q == 2'b00);
  assign cap   = armed & (sbe_i | mbe_i);

  always_comb begin
    st_d = st_q & ~clr_i;
    // multi-bit wins a same-cycle tie
    if (cap) st_d = mbe_i ? 2'b10 : 2'b01;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= '0;
      addr_q <= '0;
      syn_q  <= '0;
    end else begin
      st_q <= st_d;
      if (cap) begin
        addr_q <= addr_i[ADDR_W-1:DROP_W];
        syn_q  <= syn_i;
      end
    end
  end

  logic unused_low_addr;
  assign unused_low_addr = ^addr_i[DROP_W-1:0];

  assign st_o   = st_q;
  assign addr_o = addr_q;
  assign syn_o  = syn_q;
endmodule

// File: rtl/ecc_cap_irq.sv
module ecc_cap_irq
  import ecc_cap_pkg::*;
(
  input  logic [1:0] st_i,
  input  ecc_ctl_t   ctl_i,
  input  logic       sbe_i,
  input  logic       mbe_i,
  output logic       nmi_o,
  output logic       serr_o,
  output logic       scrub_en_o,
  output logic       scrub_req_o
);
  assign nmi_o       = st_i[BIT_SBE] & ctl_i.nmi_en;
  assign serr_o      = st_i[BIT_MBE] & ctl_i.serr_en;
  assign scrub_en_o  = ~ctl_i.scrub_dis;
  // an uncorrectable read is never written back
  assign scrub_req_o = sbe_i & ~mbe_i & ~ctl_i.scrub_dis;
endmodule

// File: rtl/ecc_err_capture.sv
module ecc_err_capture
  import ecc_cap_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int SYND_W = 8,
  parameter int KEEP_W = 19
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sbe_i,
  input  logic              mbe_i,
  input  logic [ADDR_W-1:0] err_addr_i,
  input  logic [SYND_W-1:0] syndrome_i,
  input  logic              reg_wr_i,
  input  logic [REG_W-1:0]  reg_wdata_i,
  output logic [REG_W-1:0]  reg_rdata_o,
  output logic              nmi_o,
  output logic              serr_o,
  output logic              scrub_en_o,
  output logic              scrub_req_o
);
  ecc_ctl_t          ctl, wbits;
  logic [1:0]        st, clr;
  logic [KEEP_W-1:0] addr_cap;
  logic [SYND_W-1:0] syn_cap;

  assign wbits.scrub_dis = reg_wdata_i[BIT_SCRUB_DIS];
  assign wbits.serr_en   = reg_wdata_i[BIT_SERR_EN];
  assign wbits.nmi_en    = reg_wdata_i[BIT_NMI_EN];
  assign clr             = reg_wr_i ? reg_wdata_i[BIT_MBE:BIT_SBE] : 2'b00;

  logic unused_wdata;
  assign unused_wdata = ^reg_wdata_i[BIT_SCRUB_DIS-1:SYN_LSB];

  ecc_cap_ctrl u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (reg_wr_i),
    .wbits_i (wbits),
    .ctl_o   (ctl)
  );

  ecc_cap_log #(
    .ADDR_W (ADDR_W),
    .SYND_W (SYND_W),
    .KEEP_W (KEEP_W)
  ) u_log (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sbe_i  (sbe_i),
    .mbe_i  (mbe_i),
    .addr_i (err_addr_i),
    .syn_i  (syndrome_i),
    .clr_i  (clr),
    .st_o   (st),
    .addr_o (addr_cap),
    .syn_o  (syn_cap)
  );

  ecc_cap_irq u_irq (
    .st_i        (st),
    .ctl_i       (ctl),
    .sbe_i       (sbe_i),
    .mbe_i       (mbe_i),
    .nmi_o       (nmi_o),
    .serr_o      (serr_o),
    .scrub_en_o  (scrub_en_o),
    .scrub_req_o (scrub_req_o)
  );

  assign reg_rdata_o = {ctl.scrub_dis, addr_cap, syn_cap, ctl.serr_en, ctl.nmi_en, st};
endmodule

// File: rtl/ecc_err_capture_chk.sv
module ecc_err_capture_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        sbe_i,
  input logic        mbe_i,
  input logic        reg_wr_i,
  input logic [31:0] reg_wdata_i,
  input logic [31:0] reg_rdata_o,
  input logic        nmi_o,
  input logic        serr_o,
  input logic        scrub_req_o
);
  a_r7_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_rdata_o[1:0] != 2'b00 && !reg_wr_i) |=> $stable(reg_rdata_o[1:0]));

  a_r6_hold_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_rdata_o[1:0] != 2'b00) |=> $stable(reg_rdata_o[30:4]));

  a_r6_one_status: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(reg_rdata_o[1:0]));

  a_r5_mbe_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sbe_i && mbe_i && reg_rdata_o[1:0] == 2'b00) |=> (reg_rdata_o[1:0] == 2'b10));

  a_r3_sbe_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sbe_i && !mbe_i && reg_rdata_o[1:0] == 2'b00) |=> (reg_rdata_o[1:0] == 2'b01));

  a_r9_nmi_after_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sbe_i && !mbe_i && reg_rdata_o[1:0] == 2'b00 && reg_rdata_o[2] && !reg_wr_i) |=> nmi_o);

  a_r9_serr_after_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mbe_i && reg_rdata_o[1:0] == 2'b00 && reg_rdata_o[3] && !reg_wr_i) |=> serr_o);

  a_r10_scrub_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    scrub_req_o |-> (sbe_i && !mbe_i && !reg_rdata_o[31]));

  a_r7_zero_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_wr_i && reg_wdata_i[1:0] == 2'b00 && reg_rdata_o[1:0] != 2'b00)
      |=> $stable(reg_rdata_o[1:0]));
endmodule

bind ecc_err_capture ecc_err_capture_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .sbe_i       (sbe_i),
  .mbe_i       (mbe_i),
  .reg_wr_i    (reg_wr_i),
  .reg_wdata_i (reg_wdata_i),
  .reg_rdata_o (reg_rdata_o),
  .nmi_o       (nmi_o),
  .serr_o      (serr_o),
  .scrub_req_o (scrub_req_o)
);

// File: tb/ecc_err_capture_bench.sv
`timescale 1ns/1ps
module ecc_err_capture_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sbe = 1'b0, mbe = 1'b0, wr = 1'b0;
  logic [31:0] addr = '0, wdata = '0;
  logic [7:0]  syn = '0;
  logic [31:0] rdata;
  logic        nmi, serr, scrub_en, scrub_req;

  int n_chk = 0, n_fail = 0;

  // bench model
  logic [1:0]  m_st = '0;
  logic [18:0] m_addr = '0;
  logic [7:0]  m_syn = '0;
  logic        m_sd = 1'b0, m_se = 1'b0, m_ne = 1'b0;

  always #10 clk = ~clk;

  ecc_err_capture u_ecc_err_capture (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .sbe_i       (sbe),
    .mbe_i       (mbe),
    .err_addr_i  (addr),
    .syndrome_i  (syn),
    .reg_wr_i    (wr),
    .reg_wdata_i (wdata),
    .reg_rdata_o (rdata),
    .nmi_o       (nmi),
    .serr_o      (serr),
    .scrub_en_o  (scrub_en),
    .scrub_req_o (scrub_req)
  );

  function automatic logic [31:0] exp_word();
    return {m_sd, m_addr, m_syn, m_se, m_ne, m_st};
  endfunction

  function automatic logic exp_scrub(logic s, logic m, logic sd);
    return s & ~m & ~sd;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic cyc(string tag, logic s, logic m, logic [31:0] a, logic [7:0] y,
                     logic w, logic [31:0] d);
    @(negedge clk);
    sbe = s; mbe = m; addr = a; syn = y; wr = w; wdata = d;
    #1;
    chk("R10 scrub_req", {31'd0, scrub_req}, {31'd0, exp_scrub(s, m, m_sd)});
    @(posedge clk);
    if (m_st == 2'b00 && (s || m)) begin
      m_st = m ? 2'b10 : 2'b01;
      m_addr = a[31:13];
      m_syn = y;
    end else if (w) begin
      m_st = m_st & ~d[1:0];
    end
    if (w) begin
      m_sd = d[31]; m_se = d[3]; m_ne = d[2];
    end
    #1;
    chk(tag, rdata, exp_word());
    chk("R9 nmi", {31'd0, nmi}, {31'd0, m_st[0] & m_ne});
    chk("R9 serr", {31'd0, serr}, {31'd0, m_st[1] & m_se});
    chk("R10 scrub_en", {31'd0, scrub_en}, {31'd0, ~m_sd});
  endtask

  initial begin : watchdog
    #3000000;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset word", rdata, 32'h0);
    chk("R1 reset outs", {29'd0, nmi, serr, scrub_en}, 32'h1);
    rst_n = 1'b1;
    // R2 control bits, read-only fields ignore writes
    cyc("R2 ctl write", 0, 0, 0, 0, 1, 32'hFFFF_FFFC);
    cyc("R2 ctl write", 0, 0, 0, 0, 1, 32'h0000_0004);
    // R3 sbe capture, nmi level
    cyc("R3 sbe capture", 1, 0, 32'hDEAD_BEEF, 8'h5A, 0, 0);
    // R6 later errors ignored
    cyc("R6 ignore mbe", 0, 1, 32'h1234_5678, 8'hC3, 0, 0);
    cyc("R6 ignore sbe", 1, 0, 32'h8765_4321, 8'h11, 0, 0);
    // R7 partial clear of unset bit, write 0 no effect
    cyc("R7 clear other bit", 0, 0, 0, 0, 1, 32'h0000_0006);
    cyc("R7 still disarmed", 0, 1, 32'hFFFF_0000, 8'hEE, 0, 0);
    cyc("R7 clear", 0, 0, 0, 0, 1, 32'h0000_0009);
    // R4 mbe capture with serr enabled
    cyc("R4 mbe capture", 0, 1, 32'hA5A5_E000, 8'h3C, 0, 0);
    cyc("R7 zero write", 1, 0, 32'h0, 8'h0, 1, 32'h0000_0008);
    cyc("R7 clear mbe", 0, 0, 0, 0, 1, 32'h0000_0002);
    // R5 tie
    cyc("R5 tie mbe wins", 1, 1, 32'h0F0F_F0F0, 8'h99, 0, 0);
    cyc("R7 clear both", 0, 0, 0, 0, 1, 32'h0000_0003);
    // R8 capture in a writing cycle
    cyc("R8 capture on write", 1, 0, 32'h7777_7777, 8'h42, 1, 32'h8000_0003);
    cyc("R10 scrub disabled", 1, 0, 0, 0, 0, 0);
    cyc("R7 clear sbe", 0, 0, 0, 0, 1, 32'h0000_0001);
    // random phase
    for (int i = 0; i < 4000; i++) begin
      logic s, m, w;
      logic [31:0] d;
      s = ($urandom_range(0, 3) == 0);
      m = ($urandom_range(0, 5) == 0);
      w = ($urandom_range(0, 4) == 0);
      d = $urandom();
      cyc("R6 random", s, m, $urandom(), 8'($urandom()), w, d);
    end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule